// File: doc/BRIEF.md
# Common-Clock Hit Timestamper

This block assigns arrival times to digital hit signals by counting periods of a clock that every channel shares. A free-running coarse counter advances by one on each clock edge and is visible at the ports. A rising edge on the trigger line stores the current count as the trigger time. A rising edge on any signal line stores the count as that hit's absolute time. At the same moment the block stores the hit's offset from the trigger time that is current at that instant. With a 400 MHz counting clock, one count is a 2.5 ns bin. Absolute time in seconds is the count multiplied by the clock period.

Hits are reported one per cycle on a single output. When several channels fire in the same cycle, they leave in ascending channel order. A second, independent path measures one interval directly. An edge on the start line clears a saturating interval counter. An edge on the stop line then reports the number of clock periods that have passed, with a flag if the counter reached its ceiling. All inputs are asynchronous and pass through a synchronizer before their edges are detected.

Top module: `hit_stamper`

## Requirements
- R1: After reset `tick_count` is 0, and it increases by exactly one on every clock edge, wrapping modulo 2^CW.
- R2: A rising edge on `sig_in[c]`, first sampled at clock edge k, produces one `hit_valid` pulse after edge k+3 if no lower channel is waiting. `hit_chan` equals c, and `hit_abs` equals the `tick_count` value present after edge k+1. That is the value seen just before edge k, plus 2.
- R3: `hit_rel` equals `hit_abs` minus the stored trigger time, modulo 2^CW. The trigger time is latched from `trig_in` with the same latency as a hit. A trigger edge that is latched in the same cycle as the hit gives `hit_rel` = 0. A trigger edge latched after the hit does not change that hit's `hit_rel`.
- R4: `hit_abs` and `hit_rel` stay correct when the counter wraps between the trigger and the hit.
- R5: Hits latched in the same cycle on several channels come out on consecutive cycles in ascending channel number, one per cycle.
- R6: A signal held high for many cycles produces exactly one hit.
- R7: In the interval path, a stop edge sampled n clock edges after a start edge gives `ival_count` = n. `ival_valid` is high for one cycle, after the third clock edge from the edge that first samples stop high.
- R8: The interval counter saturates at 2^IW-1. For n = 2^IW-1, `ival_ovf` is 0. For any n >= 2^IW, `ival_count` is 2^IW-1 and `ival_ovf` is 1.
- R9: A stop edge with no measurement running has no effect, so `ival_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Asynchronous trigger line, rising edge active |
| sig_in | input | NCH | Asynchronous hit lines, rising edge active |
| start_in | input | 1 | Interval start line, rising edge active |
| stop_in | input | 1 | Interval stop line, rising edge active |
| tick_count | output | CW | Free-running coarse count |
| hit_valid | output | 1 | One-cycle strobe for a reported hit |
| hit_chan | output | CHW | Channel number of the reported hit |
| hit_abs | output | CW | Absolute coarse timestamp of the hit |
| hit_rel | output | CW | Hit time minus trigger time, modulo 2^CW |
| ival_valid | output | 1 | One-cycle strobe for an interval result |
| ival_count | output | IW | Measured interval in clock periods |
| ival_ovf | output | 1 | Interval counter reached its ceiling |

## Verification
Two captures can land in the same cycle: a trigger latch and a hit latch. In that case the hit must see the new trigger time and report zero offset. The stimulus table includes vectors that raise the trigger and the signals on the same clock, and the bench expects `hit_rel` to be 0 for them. A second collision is a trigger that arrives while a hit is already latched but not yet sent. A directed case places the trigger one cycle after the hit and expects the offset to refer to the previous trigger. The offset is predicted from the `tick_count` values seen when each line was driven.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
   typedef enum logic {
      IV_IDLE = 1'b0,
      IV_RUN  = 1'b1
   } iv_state_t;

   localparam int unsigned MIN_SYNC = 2;
endpackage

// File: rtl/stamp_edge_sync.sv
module stamp_edge_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] rise
);
   initial begin
      if (STAGES < stamp_pkg::MIN_SYNC) $fatal(1, "stamp_edge_sync: STAGES too small");
      if (W < 1) $fatal(1, "stamp_edge_sync: W must be positive");
   end

   logic [STAGES-1:0][W-1:0] chain_q;
   logic [W-1:0]             last_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= '0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/stamp_hit_queue.sv
module stamp_hit_queue #(
   parameter int unsigned NCH = 4,
   parameter int unsigned CW  = 32,
   localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [CW-1:0]  now,
   input  logic           trig_rise,
   input  logic [NCH-1:0] sig_rise,
   output logic [NCH-1:0] grant,
   output logic           hit_valid,
   output logic [CHW-1:0] hit_chan,
   output logic [CW-1:0]  hit_abs,
   output logic [CW-1:0]  hit_rel
);
   logic [CW-1:0]  trig_q;
   logic [CW-1:0]  trig_ref;
   logic [NCH-1:0] pend_q;
   logic [CW-1:0]  abs_q [NCH];
   logic [CW-1:0]  rel_q [NCH];
   logic [CHW-1:0] pick;
   logic           any_pend;

   // a trigger latched this cycle is already the reference for hits latched with it
   assign trig_ref = trig_rise ? now : trig_q;

   always_ff @(posedge clk) begin
      if (!rst_n) trig_q <= '0;
      else if (trig_rise) trig_q <= now;
   end

   // lowest pending channel wins
   always_comb begin
      grant    = '0;
      pick     = '0;
      any_pend = 1'b0;
      for (int i = 0; i < NCH; i++) begin
         if (pend_q[i] && !any_pend) begin
            grant[i] = 1'b1;
            pick     = CHW'(i);
            any_pend = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         for (int c = 0; c < NCH; c++) begin
            abs_q[c] <= '0;
            rel_q[c] <= '0;
         end
      end else begin
         for (int c = 0; c < NCH; c++) begin
            if (sig_rise[c] && !pend_q[c]) begin
               pend_q[c] <= 1'b1;
               abs_q[c]  <= now;
               rel_q[c]  <= now - trig_ref;
            end else if (grant[c]) begin
               pend_q[c] <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_valid <= 1'b0;
         hit_chan  <= '0;
         hit_abs   <= '0;
         hit_rel   <= '0;
      end else begin
         hit_valid <= any_pend;
         if (any_pend) begin
            hit_chan <= pick;
            hit_abs  <= abs_q[pick];
            hit_rel  <= rel_q[pick];
         end
      end
   end
endmodule

// File: rtl/stamp_interval.sv
module stamp_interval #(
   parameter int unsigned IW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_rise,
   input  logic          stop_rise,
   output logic          ival_valid,
   output logic [IW-1:0] ival_count,
   output logic          ival_ovf
);
   import stamp_pkg::*;

   iv_state_t     state_q;
   logic [IW-1:0] run_q;
   logic          sat_q;
   logic          at_top;
   logic [IW-1:0] run_inc;

   assign at_top  = (run_q == {IW{1'b1}});
   assign run_inc = at_top ? run_q : run_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= IV_IDLE;
         run_q      <= '0;
         sat_q      <= 1'b0;
         ival_valid <= 1'b0;
         ival_count <= '0;
         ival_ovf   <= 1'b0;
      end else begin
         ival_valid <= 1'b0;
         if (start_rise) begin
            state_q <= IV_RUN;
            run_q   <= '0;
            sat_q   <= 1'b0;
         end else if (state_q == IV_RUN) begin
            if (stop_rise) begin
               state_q    <= IV_IDLE;
               ival_valid <= 1'b1;
               ival_count <= run_inc;
               ival_ovf   <= sat_q | at_top;
            end else begin
               run_q <= run_inc;
               sat_q <= sat_q | at_top;
            end
         end
      end
   end
endmodule

// File: rtl/hit_stamper.sv
module hit_stamper #(
   parameter int unsigned NCH         = 4,
   parameter int unsigned CW          = 32,
   parameter int unsigned IW          = 16,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           trig_in,
   input  logic [NCH-1:0] sig_in,
   input  logic           start_in,
   input  logic           stop_in,
   output logic [CW-1:0]  tick_count,
   output logic           hit_valid,
   output logic [CHW-1:0] hit_chan,
   output logic [CW-1:0]  hit_abs,
   output logic [CW-1:0]  hit_rel,
   output logic           ival_valid,
   output logic [IW-1:0]  ival_count,
   output logic           ival_ovf
);
   localparam int unsigned NIN = NCH + 3;

   initial begin
      if (NCH < 1)  $fatal(1, "hit_stamper: NCH must be at least 1");
      if (CW < 2)   $fatal(1, "hit_stamper: CW must be at least 2");
      if (IW < 2)   $fatal(1, "hit_stamper: IW must be at least 2");
   end

   logic [CW-1:0]  tick_q;
   logic [NIN-1:0] raw_in;
   logic [NIN-1:0] rise_all;
   logic [NCH-1:0] grant;

   always_ff @(posedge clk) begin
      if (!rst_n) tick_q <= '0;
      else        tick_q <= tick_q + 1'b1;
   end
   assign tick_count = tick_q;

   assign raw_in = {stop_in, start_in, trig_in, sig_in};

   stamp_edge_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in),
      .rise (rise_all)
   );

   stamp_hit_queue #(.NCH(NCH), .CW(CW)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .now      (tick_q),
      .trig_rise(rise_all[NCH]),
      .sig_rise (rise_all[NCH-1:0]),
      .grant    (grant),
      .hit_valid(hit_valid),
      .hit_chan (hit_chan),
      .hit_abs  (hit_abs),
      .hit_rel  (hit_rel)
   );

   stamp_interval #(.IW(IW)) u_ival (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_rise(rise_all[NCH+1]),
      .stop_rise (rise_all[NCH+2]),
      .ival_valid(ival_valid),
      .ival_count(ival_count),
      .ival_ovf  (ival_ovf)
   );
endmodule

// File: rtl/hit_stamper_chk.sv
module hit_stamper_chk #(
   parameter int unsigned NCH = 4,
   parameter int unsigned CW  = 32,
   parameter int unsigned IW  = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic [CW-1:0]  tick_count,
   input logic [NCH-1:0] grant,
   input logic           hit_valid,
   input logic           ival_valid,
   input logic [IW-1:0]  ival_count,
   input logic           ival_ovf
);
   logic warm_q;
   always_ff @(posedge clk) begin
      if (!rst_n) warm_q <= 1'b0;
      else        warm_q <= 1'b1;
   end

   assert_tick_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      warm_q |-> tick_count == $past(tick_count) + 1'b1);

   assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_hit_from_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |-> $past(grant) != '0);

   assert_ival_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ival_valid |=> !ival_valid);

   assert_ovf_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ival_valid && ival_ovf) |-> ival_count == {IW{1'b1}});
endmodule

bind hit_stamper hit_stamper_chk #(.NCH(NCH), .CW(CW), .IW(IW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_count(tick_count),
   .grant     (grant),
   .hit_valid (hit_valid),
   .ival_valid(ival_valid),
   .ival_count(ival_count),
   .ival_ovf  (ival_ovf)
);

// File: tb/hit_stamper_bench.sv
module hit_stamper_bench;
   localparam int unsigned NCH  = 4;
   localparam int unsigned CW   = 10;
   localparam int unsigned IW   = 6;
   localparam int unsigned CHW  = 2;
   localparam logic [CW-1:0] CMASK = '1;
   // each entry: [11:4] cycles from trigger to signals, [3:0] channel mask
   localparam logic [11:0] VECS [7] = '{12'h001, 12'h012, 12'h05F, 12'h03A,
                                        12'h0C4, 12'h028, 12'h076};

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           trig_in = 1'b0;
   logic [NCH-1:0] sig_in = '0;
   logic           start_in = 1'b0;
   logic           stop_in = 1'b0;
   logic [CW-1:0]  tick_count;
   logic           hit_valid;
   logic [CHW-1:0] hit_chan;
   logic [CW-1:0]  hit_abs;
   logic [CW-1:0]  hit_rel;
   logic           ival_valid;
   logic [IW-1:0]  ival_count;
   logic           ival_ovf;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   hit_stamper #(.NCH(NCH), .CW(CW), .IW(IW)) u_hit_stamper (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .sig_in(sig_in),
      .start_in(start_in), .stop_in(stop_in), .tick_count(tick_count),
      .hit_valid(hit_valid), .hit_chan(hit_chan), .hit_abs(hit_abs),
      .hit_rel(hit_rel), .ival_valid(ival_valid), .ival_count(ival_count),
      .ival_ovf(ival_ovf)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic expect_hit(input string req, input int ch, input logic [CW-1:0] abs_e,
                             input logic [CW-1:0] rel_e);
      chk({req, " valid"}, hit_valid, 1);
      chk({req, " chan"}, hit_chan, ch);
      chk({req, " abs"}, hit_abs, abs_e);
      chk({req, " rel"}, hit_rel, rel_e);
   endtask

   task automatic measure(input int n, input logic [IW-1:0] cnt_e, input logic ovf_e,
                          input string req);
      @(negedge clk); start_in = 1'b1;
      @(negedge clk); start_in = 1'b0;
      repeat (n - 1) @(negedge clk);
      stop_in = 1'b1;
      @(negedge clk); stop_in = 1'b0;
      repeat (2) @(negedge clk);
      chk({req, " ival_valid"}, ival_valid, 1);
      chk({req, " ival_count"}, ival_count, cnt_e);
      chk({req, " ival_ovf"}, ival_ovf, ovf_e);
      @(negedge clk);
      chk({req, " ival_valid drops"}, ival_valid, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R1 watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [CW-1:0] t0;
      int seen;
      // reset state (R1)
      repeat (3) @(negedge clk);
      chk("R1 tick in reset", tick_count, 0);
      chk("R1 hit_valid in reset", hit_valid, 0);
      chk("R7 ival_valid in reset", ival_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 first tick", tick_count, 1);
      @(negedge clk);
      chk("R1 second tick", tick_count, 2);
      repeat (4) @(negedge clk);

      // table walk: R2, R3 (gap 0 gives rel 0), R5 (multi-channel masks)
      for (int v = 0; v < 7; v++) begin
         int gap;
         logic [NCH-1:0] mask;
         gap  = int'(VECS[v][11:4]);
         mask = VECS[v][3:0];
         @(negedge clk);
         t0 = tick_count;
         trig_in = 1'b1;
         if (gap == 0) sig_in = mask;
         @(negedge clk);
         trig_in = 1'b0;
         sig_in  = '0;
         if (gap > 0) begin
            repeat (gap - 1) @(negedge clk);
            sig_in = mask;
            @(negedge clk);
            sig_in = '0;
         end
         repeat (3) @(negedge clk);
         for (int c = 0; c < NCH; c++) begin
            if (mask[c]) begin
               expect_hit("R2 R3 R5 table", c, (t0 + CW'(gap) + 2) & CMASK, CW'(gap));
               @(negedge clk);
            end
         end
         chk("R5 no extra hit", hit_valid, 0);
         repeat (4) @(negedge clk);
      end

      // R3: trigger latched after the hit keeps the older reference
      @(negedge clk);
      t0 = tick_count;
      trig_in = 1'b1;
      @(negedge clk); trig_in = 1'b0;
      repeat (3) @(negedge clk);
      sig_in = 4'b0010;
      @(negedge clk); sig_in = '0; trig_in = 1'b1;
      @(negedge clk); trig_in = 1'b0;
      repeat (2) @(negedge clk);
      expect_hit("R3 late trigger", 1, (t0 + 6) & CMASK, 4);
      repeat (5) @(negedge clk);

      // R6: long level yields a single hit
      seen = 0;
      @(negedge clk);
      t0 = tick_count;
      sig_in = 4'b0100;
      for (int i = 0; i < 14; i++) begin
         @(negedge clk);
         if (hit_valid) seen++;
         if (i == 7) sig_in = '0;
      end
      chk("R6 hits from held level", seen, 1);

      // R4: wrap between trigger and hit
      while (tick_count != CW'(1015)) @(negedge clk);
      t0 = tick_count;
      trig_in = 1'b1;
      @(negedge clk); trig_in = 1'b0;
      repeat (9) @(negedge clk);
      sig_in = 4'b1000;
      @(negedge clk); sig_in = '0;
      repeat (3) @(negedge clk);
      expect_hit("R4 wrap", 3, 3, 10);
      repeat (4) @(negedge clk);

      // interval path R7, R8
      measure(5, 5, 1'b0, "R7 n=5");
      measure(1, 1, 1'b0, "R7 n=1");
      measure(63, 63, 1'b0, "R8 n=63");
      measure(64, 63, 1'b1, "R8 n=64");
      measure(90, 63, 1'b1, "R8 n=90");

      // R9: stop with nothing running
      seen = 0;
      @(negedge clk); stop_in = 1'b1;
      @(negedge clk); stop_in = 1'b0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (ival_valid) seen++;
      end
      chk("R9 stray stop", seen, 0);
      chk("R9 result unchanged", ival_count, 63);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule